// File: doc/BRIEF.md
# Hub SPI Host Transaction Engine

This block is the host-side SPI master for a mixed-signal monitoring hub. Every pin on the hub can act as an analog input or as a general-purpose I/O. A client sends one request at a time. A request carries an operation code, a 5-bit address or channel number, and a data byte for writes. The engine builds the command byte and clocks one or two 16-bit frames in SPI mode 0 (clock idles low, data launched on the falling edge, sampled on the rising edge, MSB first). It then returns the captured word split into a result field and a status flag.

Reads need two frames. The first frame carries the command and its incoming bits are discarded. Chip select then returns high for a programmable minimum time, and the second frame carries the answer back. Writes need a single frame: the command byte, then the data byte. Register requests that address outside the 16 I/O registers, and the reserved operation code, are refused with an error response and cause no bus activity.

The serial clock half-period (`sckHalf`, in system clocks, 0 treated as 1) and the minimum chip-select-high time (`csHighMin`) are inputs. They are sampled live, so they are expected to change only while the engine is idle.

Top module: `hubSpiHost`

## Requirements
- R1: After reset, `csN` is 1, `sclk` is 0, `busy` is 0 and `done` is 0.
- R2: Operation code 0 (analog channel read) sends first-frame word {3'b000, channel[4:0], 8'h00}. It then runs a second frame and returns bits 11:0 of that frame's MISO word on `respData` and bit 14 on `respFlag`. MISO bits of the first frame have no effect on the result.
- R3: Operation code 1 (register read) sends first-frame word {8'h30 | addr[3:0], 8'h00}, with the I/O-space bit 5 and the read bit 4 both set. It returns {4'h0, bits 7:0 of the second frame's MISO word} on `respData`, with `respFlag` 0.
- R4: Operation code 2 (register write) runs exactly one frame carrying {8'h20 | addr[3:0], data[7:0]}, with the read bit clear. It returns `respData` 0 and `respFlag` 0.
- R5: A request with operation code 3, or with code 1 or 2 and `reqAddr` above 15, produces no chip-select activity. `done` rises in the cycle after acceptance, with `respErr` 1 and `respData` 0. Successful requests return `respErr` 0.
- R6: Between the two frames of a read, and between consecutive transactions, `csN` stays high for at least `csHighMin` system clocks.
- R7: In every frame, `sclk` is low whenever `csN` is high or changes. The frame has exactly 16 rising edges, and `csN` stays low for 32·`sckHalf` system clocks.
- R8: `busy` is high from acceptance until the transaction ends. Requests presented while `busy` is high are ignored and do not alter the running transaction or its result.
- R9: `done` is high for exactly one cycle: the cycle in which `csN` returns high after the final frame (or, for a refused request, the cycle after acceptance). The response outputs then hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqOp | input | 2 | 0 analog read, 1 register read, 2 register write, 3 reserved |
| reqAddr | input | 5 | Register address or channel number |
| reqWrData | input | 8 | Write data byte |
| sckHalf | input | DIV_W | Serial clock half-period in system clocks |
| csHighMin | input | GAP_W | Minimum chip-select-high time in system clocks |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| respData | output | 12 | Sample or register byte |
| respFlag | output | 1 | Pin-muxed-as-GPIO flag from analog reads |
| respErr | output | 1 | Request refused |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Host-to-hub serial data |
| miso | input | 1 | Hub-to-host serial data |

## Verification
The checks on chip-select gap and frame length assume that `sckHalf` and `csHighMin` hold steady while `busy` is high. The bench changes them only between transactions, after `done`, and keeps `sckHalf` between 1 and 4. The bench's hub model changes `miso` only on falling serial-clock edges and at chip-select assertion, as a mode-0 target does, so the rising-edge samples see settled data. Requests sent while busy are pushed deliberately, to show that the latched request survives them.

// File: rtl/hubSpiPkg.sv
package hubSpiPkg;

  typedef enum logic [1:0] {
    OP_ADC    = 2'd0,
    OP_REG_RD = 2'd1,
    OP_REG_WR = 2'd2,
    OP_RSVD   = 2'd3
  } hubOpE;

  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned BIT_CNT_W  = $clog2(FRAME_BITS);
  localparam logic [7:0]  IO_SPACE   = 8'h20;
  localparam logic [7:0]  READ_BIT   = 8'h10;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;    // latch a good request
    logic loadTx;    // load the transmit shifter at frame start
    logic txSel;     // 0: command word, 1: idle word for the data frame
    logic sampleBit; // rising serial edge: take one MISO bit
    logic shiftBit;  // falling serial edge: present the next MOSI bit
    logic capture;   // last frame ended: publish the response
    logic reject;    // refused request: publish the error response
  } ctrlStrobeS;

endpackage

// File: rtl/hubSpiCtrl.sv
module hubSpiCtrl
  import hubSpiPkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic             reqAddrHi,
  input  logic [DIV_W-1:0] sckHalf,
  input  logic [GAP_W-1:0] csHighMin,
  output ctrlStrobeS       strobe,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             csN
);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_LOW, S_HIGH} stateE;

  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_BITS - 1);

  stateE              state;
  logic               twoFrames;
  logic               frameIdx;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [DIV_W-1:0]   halfCnt;
  logic [GAP_W:0]     gapCnt;

  logic [DIV_W-1:0] halfLast;
  logic badReq, acceptAny, halfDone, lastBit, gapOk, frameEnd, finish;

  always_comb begin
    halfLast  = (sckHalf == '0) ? '0 : sckHalf - 1'b1;
    halfDone  = (halfCnt == halfLast);
    lastBit   = (bitCnt == LAST_BIT);
    gapOk     = (gapCnt >= {1'b0, csHighMin});
    badReq    = (reqOp == OP_RSVD) || ((reqOp != OP_ADC) && reqAddrHi);
    acceptAny = (state == S_IDLE) && reqValid;
    frameEnd  = (state == S_HIGH) && halfDone && lastBit;
    finish    = frameEnd && (!twoFrames || frameIdx);

    strobe.accept    = acceptAny && !badReq;
    strobe.reject    = acceptAny && badReq;
    strobe.loadTx    = (state == S_GAP) && gapOk;
    strobe.txSel     = frameIdx;
    strobe.sampleBit = (state == S_LOW) && halfDone;
    strobe.shiftBit  = (state == S_HIGH) && halfDone && !lastBit;
    strobe.capture   = finish;
  end

  assign busy = (state != S_IDLE);

  // time since chip select last went high, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '1;
    end else if (frameEnd) begin
      gapCnt <= '0;
    end else if (csN && !(&gapCnt)) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      twoFrames <= 1'b0;
      frameIdx  <= 1'b0;
      bitCnt    <= '0;
      halfCnt   <= '0;
      sclk      <= 1'b0;
      csN       <= 1'b1;
      done      <= 1'b0;
    end else begin
      done <= finish || strobe.reject;
      unique case (state)
        S_IDLE: begin
          if (strobe.accept) begin
            state     <= S_GAP;
            twoFrames <= (reqOp != OP_REG_WR);
            frameIdx  <= 1'b0;
          end
        end
        S_GAP: begin
          if (gapOk) begin
            csN     <= 1'b0;
            state   <= S_LOW;
            halfCnt <= '0;
            bitCnt  <= '0;
          end
        end
        S_LOW: begin
          if (halfDone) begin
            sclk    <= 1'b1;
            halfCnt <= '0;
            state   <= S_HIGH;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        S_HIGH: begin
          if (halfDone) begin
            sclk    <= 1'b0;
            halfCnt <= '0;
            if (lastBit) begin
              csN <= 1'b1;
              if (finish) begin
                state <= S_IDLE;
              end else begin
                state    <= S_GAP;
                frameIdx <= 1'b1;
              end
            end else begin
              bitCnt <= bitCnt + 1'b1;
              state  <= S_LOW;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hubSpiData.sv
module hubSpiData
  import hubSpiPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStrobeS strobe,
  input  logic [1:0] reqOp,
  input  logic [4:0] reqAddr,
  input  logic [7:0] reqWrData,
  input  logic       miso,
  output logic       mosi,
  output logic [11:0] respData,
  output logic       respFlag,
  output logic       respErr
);

  hubOpE                 opHeld;
  logic [FRAME_BITS-1:0] cmdWord;
  logic [FRAME_BITS-1:0] txSh;
  logic [FRAME_BITS-1:0] rxSh;
  logic [FRAME_BITS-1:0] cmdNext;

  always_comb begin
    unique case (hubOpE'(reqOp))
      OP_ADC:    cmdNext = {3'b000, reqAddr, 8'h00};
      OP_REG_RD: cmdNext = {IO_SPACE | READ_BIT | {4'h0, reqAddr[3:0]}, 8'h00};
      default:   cmdNext = {IO_SPACE | {4'h0, reqAddr[3:0]}, reqWrData};
    endcase
  end

  assign mosi = txSh[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opHeld   <= OP_ADC;
      cmdWord  <= '0;
      txSh     <= '0;
      rxSh     <= '0;
      respData <= '0;
      respFlag <= 1'b0;
      respErr  <= 1'b0;
    end else begin
      if (strobe.accept) begin
        opHeld  <= hubOpE'(reqOp);
        cmdWord <= cmdNext;
      end
      if (strobe.loadTx) begin
        txSh <= strobe.txSel ? '0 : cmdWord;
      end else if (strobe.shiftBit) begin
        txSh <= {txSh[FRAME_BITS-2:0], 1'b0};
      end
      if (strobe.sampleBit) begin
        rxSh <= {rxSh[FRAME_BITS-2:0], miso};
      end
      if (strobe.capture) begin
        respErr <= 1'b0;
        unique case (opHeld)
          OP_ADC: begin
            respData <= rxSh[11:0];
            respFlag <= rxSh[14];
          end
          OP_REG_RD: begin
            respData <= {4'h0, rxSh[7:0]};
            respFlag <= 1'b0;
          end
          default: begin
            respData <= '0;
            respFlag <= 1'b0;
          end
        endcase
      end else if (strobe.reject) begin
        respErr  <= 1'b1;
        respData <= '0;
        respFlag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/hubSpiHost.sv
module hubSpiHost
  import hubSpiPkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [4:0]       reqAddr,
  input  logic [7:0]       reqWrData,
  input  logic [DIV_W-1:0] sckHalf,
  input  logic [GAP_W-1:0] csHighMin,
  output logic             busy,
  output logic             done,
  output logic [11:0]      respData,
  output logic             respFlag,
  output logic             respErr,
  output logic             sclk,
  output logic             csN,
  output logic             mosi,
  input  logic             miso
);

  ctrlStrobeS strobe;

  hubSpiCtrl #(.DIV_W(DIV_W), .GAP_W(GAP_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .reqAddrHi (reqAddr[4]),
    .sckHalf   (sckHalf),
    .csHighMin (csHighMin),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done),
    .sclk      (sclk),
    .csN       (csN)
  );

  hubSpiData uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqOp     (reqOp),
    .reqAddr   (reqAddr),
    .reqWrData (reqWrData),
    .miso      (miso),
    .mosi      (mosi),
    .respData  (respData),
    .respFlag  (respFlag),
    .respErr   (respErr)
  );

endmodule

// File: rtl/hubSpiHostChk.sv
module hubSpiHostChk #(
  parameter int unsigned GAP_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [GAP_W-1:0] csHighMin,
  input logic             busy,
  input logic             done,
  input logic [11:0]      respData,
  input logic             respFlag,
  input logic             respErr,
  input logic             sclk,
  input logic             csN
);

  logic [GAP_W:0] hiCnt;
  logic [4:0]     riseCnt;
  logic           sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt    <= '1;
      riseCnt  <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkPrev <= sclk;
      if (csN) begin
        riseCnt <= '0;
        if (!(&hiCnt)) hiCnt <= hiCnt + 1'b1;
      end else begin
        hiCnt <= '0;
        if (sclk && !sclkPrev) riseCnt <= riseCnt + 1'b1;
      end
    end
  end

  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  assert_cs_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(csN) || $rose(csN)) |-> !sclk);

  assert_frame_edges_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (riseCnt == 5'd16));

  assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (hiCnt >= {1'b0, csHighMin}));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({respData, respFlag, respErr}));

  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && respErr) |-> (csN && $past(csN) && respData == 12'h000));

  assert_busy_cs_R8: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind hubSpiHost hubSpiHostChk #(.GAP_W(GAP_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .csHighMin (csHighMin),
  .busy      (busy),
  .done      (done),
  .respData  (respData),
  .respFlag  (respFlag),
  .respErr   (respErr),
  .sclk      (sclk),
  .csN       (csN)
);

// File: tb/sim_hubSpiHost.sv
module sim_hubSpiHost;

  localparam int DIV_W = 8;
  localparam int GAP_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rstN;
  logic             reqValid;
  logic [1:0]       reqOp;
  logic [4:0]       reqAddr;
  logic [7:0]       reqWrData;
  logic [DIV_W-1:0] sckHalf;
  logic [GAP_W-1:0] csHighMin;
  logic             busy, done, respFlag, respErr, sclk, csN, mosi;
  logic [11:0]      respData;
  logic             miso;

  int nTests = 0;
  int nFail  = 0;

  hubSpiHost #(.DIV_W(DIV_W), .GAP_W(GAP_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .sckHalf(sckHalf),
    .csHighMin(csHighMin), .busy(busy), .done(done), .respData(respData),
    .respFlag(respFlag), .respErr(respErr), .sclk(sclk), .csN(csN),
    .mosi(mosi), .miso(miso)
  );

  function automatic void check(bit ok, string req, string what,
                                longint act, longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  // ---------------- hub model ----------------
  logic [15:0] slvTx [2];
  logic [15:0] mosiLog [4];
  logic [15:0] slvSh, slvRx;
  int frameNo = 0;

  always @(negedge csN) if (rstN) begin
    slvSh = slvTx[(frameNo < 2) ? frameNo : 1];
    miso  = slvSh[15];
    slvRx = 16'h0;
  end
  always @(posedge sclk) if (!csN) slvRx = {slvRx[14:0], mosi};
  always @(negedge sclk) if (!csN) begin
    slvSh = {slvSh[14:0], 1'b0};
    miso  = slvSh[15];
  end
  always @(posedge csN) if (rstN) begin
    if (frameNo < 4) mosiLog[frameNo] = slvRx;
    frameNo++;
  end

  // ---------------- bus timing monitor ----------------
  int  curLow = 0, curRise = 0, hiCnt = 1000;
  logic prevCs = 1'b1, prevSclk = 1'b0;

  always @(negedge clk) if (rstN) begin
    if (!csN && prevCs) begin
      check(hiCnt >= int'(csHighMin), "R6", "cs high gap", hiCnt, csHighMin);
      curLow  = 1;
      curRise = 0;
      check(!sclk, "R7", "sclk at cs fall", sclk, 0);
    end else if (!csN) begin
      curLow++;
      if (sclk && !prevSclk) curRise++;
    end
    if (csN && !prevCs) begin
      check(curLow == 32 * int'(sckHalf), "R7", "cs low length", curLow, 32 * sckHalf);
      check(curRise == 16, "R7", "rising edges", curRise, 16);
      hiCnt = 1;
    end else if (csN) begin
      hiCnt++;
    end
    prevCs   = csN;
    prevSclk = sclk;
  end

  // ---------------- expected values ----------------
  function automatic bit expErr(logic [1:0] op, logic [4:0] a);
    return (op == 2'd3) || ((op != 2'd0) && a[4]);
  endfunction

  function automatic int expFrames(logic [1:0] op, logic [4:0] a);
    if (expErr(op, a)) return 0;
    return (op == 2'd2) ? 1 : 2;
  endfunction

  function automatic logic [15:0] expCmd(logic [1:0] op, logic [4:0] a, logic [7:0] d);
    case (op)
      2'd0:    return {3'b000, a, 8'h00};
      2'd1:    return {4'h3, a[3:0], 8'h00};
      default: return {4'h2, a[3:0], d};
    endcase
  endfunction

  function automatic logic [11:0] expData(logic [1:0] op, logic [15:0] w);
    case (op)
      2'd0:    return w[11:0];
      2'd1:    return {4'h0, w[7:0]};
      default: return 12'h000;
    endcase
  endfunction

  function automatic string reqTag(logic [1:0] op, logic [4:0] a);
    if (expErr(op, a)) return "R5";
    case (op)
      2'd0:    return "R2";
      2'd1:    return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic runTxn(logic [1:0] op, logic [4:0] a, logic [7:0] d,
                        logic [15:0] w0, logic [15:0] w1, bit poke);
    string tag;
    int cyc;
    logic [11:0] heldData;
    tag = reqTag(op, a);
    slvTx[0] = w0;
    slvTx[1] = w1;
    frameNo  = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqWrData = d;
    @(negedge clk);
    reqValid = 1'b0;
    if (expErr(op, a)) begin
      check(done == 1'b1, "R5", "done one cycle after refusal", done, 1);
    end
    if (poke && !expErr(op, a)) begin
      check(busy == 1'b1, "R8", "busy after accept", busy, 1);
      reqValid = 1'b1; reqOp = 2'd2; reqAddr = 5'd9; reqWrData = 8'h3C;
      repeat (4) @(negedge clk);
      reqValid = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    check(done == 1'b1, tag, "done seen", done, 1);
    check(csN == 1'b1, "R9", "cs high at done", csN, 1);
    check(respErr == expErr(op, a), tag, "respErr", respErr, expErr(op, a));
    check(respData == expData(expErr(op, a) ? 2'd3 : op, w1), tag, "respData",
          respData, expData(expErr(op, a) ? 2'd3 : op, w1));
    check(respFlag == ((op == 2'd0) ? w1[14] : 1'b0), tag, "respFlag",
          respFlag, (op == 2'd0) ? w1[14] : 1'b0);
    check(frameNo == expFrames(op, a), poke ? "R8" : tag, "frame count",
          frameNo, expFrames(op, a));
    if (expFrames(op, a) > 0)
      check(mosiLog[0] == expCmd(op, a, d), poke ? "R8" : tag, "command word",
            mosiLog[0], expCmd(op, a, d));
    heldData = respData;
    @(negedge clk);
    check(done == 1'b0, "R9", "done single cycle", done, 0);
    check(respData == heldData, "R9", "result held", respData, heldData);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; reqValid = 1'b0; reqOp = 2'd0; reqAddr = 5'd0; reqWrData = 8'h00;
    sckHalf = 8'd2; csHighMin = 8'd3; miso = 1'b0;
    slvTx[0] = 16'h0; slvTx[1] = 16'h0;
    repeat (4) @(negedge clk);
    check(csN == 1'b1, "R1", "csN in reset", csN, 1);
    check(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);

    // directed corners
    runTxn(2'd0, 5'd0,  8'h00, 16'hFFFF, 16'h4ABC, 1'b0); // R2 flag set, first frame junk
    runTxn(2'd0, 5'd31, 8'h00, 16'h1234, 16'hBFFF, 1'b0); // R2 flag clear, top bits junk
    runTxn(2'd0, 5'd17, 8'h00, 16'h0000, 16'h0001, 1'b0); // R2 channel above 15 valid
    runTxn(2'd1, 5'd15, 8'h00, 16'hFFFF, 16'hFF5A, 1'b0); // R3 top address
    runTxn(2'd1, 5'd0,  8'h00, 16'h0000, 16'h00C3, 1'b0); // R3
    runTxn(2'd2, 5'd0,  8'hA5, 16'hFFFF, 16'hFFFF, 1'b0); // R4
    runTxn(2'd2, 5'd15, 8'h01, 16'h0000, 16'h0000, 1'b0); // R4
    runTxn(2'd1, 5'd16, 8'h00, 16'h0000, 16'h0FFF, 1'b0); // R5
    runTxn(2'd2, 5'd31, 8'h77, 16'h0000, 16'h0FFF, 1'b0); // R5
    runTxn(2'd3, 5'd2,  8'h00, 16'h0000, 16'h0FFF, 1'b0); // R5 reserved code
    runTxn(2'd0, 5'd6,  8'h00, 16'h0000, 16'h4321, 1'b1); // R8 pokes while busy
    runTxn(2'd1, 5'd4,  8'h00, 16'h0000, 16'h0099, 1'b1); // R8

    sckHalf = 8'd1; csHighMin = 8'd0;                     // R6 R7 minimum settings
    runTxn(2'd0, 5'd9, 8'h00, 16'h0000, 16'h0777, 1'b0);

    // constrained random
    for (int i = 0; i < 60; i++) begin
      logic [1:0]  op;
      logic [4:0]  a;
      logic [7:0]  d;
      logic [15:0] w0, w1;
      sckHalf   = 8'($urandom_range(1, 4));
      csHighMin = 8'($urandom_range(0, 7));
      op = 2'($urandom_range(0, 3));
      a  = 5'($urandom);
      d  = 8'($urandom);
      w0 = 16'($urandom);
      w1 = 16'($urandom);
      runTxn(op, a, d, w0, w1, ($urandom_range(0, 4) == 0));
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule